// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block decides which interrupt a 16550-style serial port reports and drives its single interrupt line. Its inputs are the live status from the rest of the port: receive error flags, data-ready, the receive FIFO fill count and its trigger level, a character-timeout flag, the holding-register-empty condition and the modem-status change flags. From these and a locally held 4-bit enable register it forms the identification byte that software reads. That byte names the one highest-priority pending source.

The block also holds the "transmitter holding register empty" pending flag. An event from the transmit path sets it. A write to the enable register also sets it while the holding register is empty. A write to the holding register clears it. A read of the identification byte clears it, but only while that byte is showing the transmitter code. The interrupt output is a registered level. It is high one cycle after the identification code becomes anything other than "nothing pending".

Top module: `uart_irq_ident`

## Requirements
- R1: Receiver line status has the highest priority. When enable bit 2 is set and any bit of the 4-bit error vector `ls_err` (break, framing, parity, overrun) is set, `iid[3:0]` = 0x6.
- R2: The character timeout reports `iid[3:0]` = 0xC. It needs enable bit 0 and `timeout_pend`. It ranks below line status and above received data. With enable bit 0 clear it never appears.
- R3: Received data available reports `iid[3:0]` = 0x4. It needs enable bit 0 and `data_ready`, and either `fifo_en` low or `rx_count` >= `rx_trig`.
- R4: Transmitter-empty reports `iid[3:0]` = 0x2 when enable bit 1 is set and the pending flag is set. It ranks below received data.
- R5: Modem status reports `iid[3:0]` = 0x0 when enable bit 3 is set and any bit of `msr_delta` is set. It ranks lowest. With no source active, `iid[3:0]` = 0x1.
- R6: `iid[7:6]` reads 2'b11 while `fifo_en` is high and 2'b00 otherwise. `iid[5:4]` is always 0.
- R7: `irq` is registered. After each clock edge it is high exactly when `iid[3:0]` was not 0x1 just before that edge.
- R8: A write to the enable register stores only `ier_wdata[3:0]`, and `ier_q` shows it after the edge. If `thr_empty` is high during that write, the pending flag is set.
- R9: An identification read (`iid_rd`) clears the pending flag when `iid[3:0]` is 0x2 in that cycle. A read while another code is showing leaves the flag unchanged.
- R10: A holding-register write (`thr_wr`) clears the pending flag. It overrides any set in the same cycle.
- R11: A `thre_set` pulse sets the pending flag. It overrides an identification-read clear in the same cycle.
- R12: After reset, `ier_q` = 0, the pending flag is clear, `iid` = 0x01 with `fifo_en` low, and `irq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Write data; only bits 3:0 are kept |
| thr_wr | input | 1 | Holding register write strobe |
| iid_rd | input | 1 | Identification register read strobe |
| thre_set | input | 1 | Transmit path reports the holding register emptied |
| thr_empty | input | 1 | Holding register currently empty |
| ls_err | input | 4 | Break, framing, parity and overrun flags |
| data_ready | input | 1 | Received data available |
| fifo_en | input | 1 | FIFO mode active |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive trigger level |
| timeout_pend | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status change flags |
| ier_q | output | 4 | Stored enable bits |
| iid | output | 8 | Identification byte |
| irq | output | 1 | Registered interrupt level |

## Verification
The assertions assume that each strobe is a single-cycle pulse sampled at the rising edge. They also assume that status inputs change only between edges, so the code seen before an edge is the code that acknowledge and `irq` act on. The ack property leaves out cycles that also carry a set source, because R11 and R8 let those re-set the flag. The stimulus drives every input on the falling edge and keeps strobes one cycle wide. Collisions between set and clear are produced only in dedicated directed steps.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    ID_MODEM   = 4'h0,
    ID_NONE    = 4'h1,
    ID_THRE    = 4'h2,
    ID_RXDATA  = 4'h4,
    ID_LINE    = 4'h6,
    ID_TIMEOUT = 4'hC
  } irq_id_e;

  // one request line per source, already qualified by its enable
  typedef struct packed {
    logic line;
    logic timeout;
    logic rxdata;
    logic thre;
    logic modem;
  } irq_req_t;

  // fixed-order resolution: first active request wins
  function automatic irq_id_e resolve_id(irq_req_t r);
    if (r.line)         return ID_LINE;
    else if (r.timeout) return ID_TIMEOUT;
    else if (r.rxdata)  return ID_RXDATA;
    else if (r.thre)    return ID_THRE;
    else if (r.modem)   return ID_MODEM;
    else                return ID_NONE;
  endfunction

  // FIFO bits of the identification byte
  function automatic logic [1:0] fifo_tag(logic fifo_on);
    return fifo_on ? 2'b11 : 2'b00;
  endfunction

endpackage

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [3:0]       ier,
  input  logic [3:0]       ls_err,
  input  logic             data_ready,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             timeout_pend,
  input  logic             thr_pend,
  input  logic [3:0]       msr_delta,
  output irq_req_t         req,
  output logic [3:0]       id_code
);

  logic level_met;

  assign level_met = !fifo_en || (rx_count >= rx_trig);

  always_comb begin
    req.line    = ier[2] && (|ls_err);
    req.timeout = ier[0] && timeout_pend;
    req.rxdata  = ier[0] && data_ready && level_met;
    req.thre    = ier[1] && thr_pend;
    req.modem   = ier[3] && (|msr_delta);
    id_code     = resolve_id(req);
  end

endmodule

// File: rtl/uart_irq_thr_flag.sv
module uart_irq_thr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ier_wr,
  input  logic thr_empty,
  input  logic thre_set,
  input  logic thr_wr,
  input  logic ack,
  output logic pend
);

  logic set_req;

  assign set_req = thre_set || (ier_wr && thr_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (thr_wr)  pend <= 1'b0;
    else if (set_req) pend <= 1'b1;
    else if (ack)     pend <= 1'b0;
  end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  input  logic             thr_wr,
  input  logic             iid_rd,
  input  logic             thre_set,
  input  logic             thr_empty,
  input  logic [3:0]       ls_err,
  input  logic             data_ready,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             timeout_pend,
  input  logic [3:0]       msr_delta,
  output logic [3:0]       ier_q,
  output logic [7:0]       iid,
  output logic             irq
);

  logic       thr_pend;
  logic       thr_ack;
  logic [3:0] id_code;
  irq_req_t   req;
  logic       unused_hi;

  assign unused_hi = ^ier_wdata[7:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ier_q <= 4'h0;
    else if (ier_wr) ier_q <= ier_wdata[3:0];
  end

  uart_irq_prio #(.CNT_W(CNT_W)) u_prio (
    .ier          (ier_q),
    .ls_err       (ls_err),
    .data_ready   (data_ready),
    .fifo_en      (fifo_en),
    .rx_count     (rx_count),
    .rx_trig      (rx_trig),
    .timeout_pend (timeout_pend),
    .thr_pend     (thr_pend),
    .msr_delta    (msr_delta),
    .req          (req),
    .id_code      (id_code)
  );

  // the read only acknowledges the transmitter source while it is the one shown
  assign thr_ack = iid_rd && (id_code == ID_THRE);

  uart_irq_thr_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .ier_wr    (ier_wr),
    .thr_empty (thr_empty),
    .thre_set  (thre_set),
    .thr_wr    (thr_wr),
    .ack       (thr_ack),
    .pend      (thr_pend)
  );

  assign iid = {fifo_tag(fifo_en), 2'b00, id_code};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (id_code != ID_NONE);
  end

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ier_wr,
  input logic [7:0] ier_wdata,
  input logic       thr_wr,
  input logic       iid_rd,
  input logic       thre_set,
  input logic       thr_empty,
  input logic [3:0] ls_err,
  input logic [3:0] ier_q,
  input logic [7:0] iid,
  input logic       irq,
  input logic       thr_pend
);

  a_r1_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_q[2] && (|ls_err)) |-> (iid[3:0] == 4'h6));

  a_r2_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!ier_q[0]) |-> (iid[3:0] != 4'hC && iid[3:0] != 4'h4));

  a_r7_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    (iid[3:0] != 4'h1) |=> irq);

  a_r7_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    (iid[3:0] == 4'h1) |=> !irq);

  a_r8_ier_store: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> (ier_q == $past(ier_wdata[3:0])));

  a_r9_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_rd && iid[3:0] == 4'h2 && !thre_set && !(ier_wr && thr_empty)) |=> !thr_pend);

  a_r10_write_clear: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thr_pend);

  a_r11_event_set: assert property (@(posedge clk) disable iff (!rst_n)
    (thre_set && !thr_wr) |=> thr_pend);

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ier_wr    (ier_wr),
  .ier_wdata (ier_wdata),
  .thr_wr    (thr_wr),
  .iid_rd    (iid_rd),
  .thre_set  (thre_set),
  .thr_empty (thr_empty),
  .ls_err    (ls_err),
  .ier_q     (ier_q),
  .iid       (iid),
  .irq       (irq),
  .thr_pend  (thr_pend)
);

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;

  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ier_wr = 0, thr_wr = 0, iid_rd = 0, thre_set = 0, thr_empty = 0;
  logic [7:0]    ier_wdata = 0;
  logic [3:0]    ls_err = 0, msr_delta = 0;
  logic          data_ready = 0, fifo_en = 0, timeout_pend = 0;
  logic [CW-1:0] rx_count = 0, rx_trig = 0;
  logic [3:0]    ier_q;
  logic [7:0]    iid;
  logic          irq;

  int  vectors = 0;
  int  fails = 0;
  bit  done = 0;

  always #10 clk = ~clk;

  uart_irq_ident #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .thr_wr(thr_wr), .iid_rd(iid_rd), .thre_set(thre_set), .thr_empty(thr_empty),
    .ls_err(ls_err), .data_ready(data_ready), .fifo_en(fifo_en),
    .rx_count(rx_count), .rx_trig(rx_trig), .timeout_pend(timeout_pend),
    .msr_delta(msr_delta), .ier_q(ier_q), .iid(iid), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'h6: return "R1";
      4'hC: return "R2";
      4'h4: return "R3";
      4'h2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R12 reset values
    chk("R12 ier", {4'h0, ier_q}, 8'h00);
    chk("R12 iid", iid, 8'h01);
    chk("R12 irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep every enable pattern against every source combination
    for (int e = 0; e < 16; e++) begin
      for (int m = 0; m < 64; m++) begin
        for (int lv = 0; lv < 3; lv++) begin
          logic lse, to, dr, fe, pd, md, rxok;
          logic [3:0] en, code;
          logic [CW-1:0] cnt;
          en = e[3:0];
          lse = m[0]; to = m[1]; dr = m[2]; fe = m[3]; pd = m[4]; md = m[5];
          cnt = (lv == 0) ? 5'd3 : (lv == 1) ? 5'd4 : 5'd9;
          // cycle A: write enables (noise in top nibble), set flag if wanted
          ls_err       = lse ? (4'b0001 << (e % 4)) : 4'b0000;
          msr_delta    = md ? (4'b1000 >> ((e + m) % 4)) : 4'b0000;
          timeout_pend = to;
          data_ready   = dr;
          fifo_en      = fe;
          rx_trig      = 5'd4;
          rx_count     = cnt;
          ier_wr       = 1'b1;
          ier_wdata    = {4'(m ^ e ^ 4'hA), en};
          thr_empty    = pd;
          @(negedge clk);
          ier_wr    = 1'b0;
          thr_empty = 1'b0;
          thr_wr    = !pd;
          @(negedge clk);
          thr_wr = 1'b0;
          rxok = (fe == 1'b0) ? 1'b1 : (cnt > 5'd3);
          if (en[2] & lse)             code = 4'h6;
          else if (en[0] & to)         code = 4'hC;
          else if (en[0] & dr & rxok)  code = 4'h4;
          else if (en[1] & pd)         code = 4'h2;
          else if (en[3] & md)         code = 4'h0;
          else                         code = 4'h1;
          chk("R8 ier low nibble", {4'h0, ier_q}, {4'h0, en});
          chk({tag_of(code), " R6 iid"}, iid, {fe, fe, 2'b00, code});
          @(negedge clk);
          chk("R7 irq", {7'b0, irq}, {7'b0, code != 4'h1});
        end
      end
    end

    // directed: acknowledge rules
    ls_err = 0; msr_delta = 0; timeout_pend = 0; data_ready = 0; fifo_en = 0;
    ier_wr = 1; ier_wdata = 8'hF3; thr_empty = 1;
    @(negedge clk);
    ier_wr = 0; thr_empty = 0;
    chk("R8 set on enable write", iid, 8'h02);
    iid_rd = 1;
    @(negedge clk);
    iid_rd = 0;
    chk("R9 read clears", iid, 8'h01);
    thre_set = 1;
    @(negedge clk);
    thre_set = 0;
    chk("R11 event sets", iid, 8'h02);
    data_ready = 1;
    @(negedge clk);
    chk("R3 over thre", iid, 8'h04);
    iid_rd = 1;
    @(negedge clk);
    iid_rd = 0; data_ready = 0;
    @(negedge clk);
    chk("R9 other code keeps flag", iid, 8'h02);
    iid_rd = 1; thre_set = 1;
    @(negedge clk);
    iid_rd = 0; thre_set = 0;
    chk("R11 set beats ack", iid, 8'h02);
    thr_wr = 1; thre_set = 1;
    @(negedge clk);
    thr_wr = 0; thre_set = 0;
    chk("R10 write beats set", iid, 8'h01);
    @(negedge clk);
    chk("R7 irq low", {7'b0, irq}, 8'h00);
    thre_set = 1;
    @(negedge clk);
    thre_set = 0; thr_wr = 1;
    @(negedge clk);
    thr_wr = 0;
    chk("R10 write clears", iid, 8'h01);

    finish_run();
  end

endmodule